// File: doc/BRIEF.md
# Satellite Tone Burst Generator

This block makes the 22 kHz signalling tone that is superimposed on the LNB supply line, and picks where that tone comes from. A one-cycle tick from the boost converter oscillator, which runs at twenty times the tone rate, is divided down to a symmetric square wave. Two control bits then choose among three sources:
- a tone that runs all the time;
- the internal tone, switched on and off by a modulation pin;
- an already modulated external tone on that same pin, passed straight through.

The modulation pin is asynchronous and is brought into the clock domain by a two-flop synchroniser. In the switched mode a burst does not end on the first low level of the pin. It lasts until a fixed number of ticks after the last rising edge, a little more than one tone period. This lets a pin that carries a gated square wave hold the burst open between its own pulses. A separate output picks the threshold for the tone detector, transmit or receive, from a pin and a register bit.

Top module: `tone_burst_gen`

## Requirements
- R1: The internal tone has a period of DIV_RATIO (default 20) ticks of `osc_tick`. Its phase counter starts at 0 and steps once per tick. The tone is high while the phase is below DIV_RATIO/2 and low for the rest, so it is high for half of the ticks.
- R2: With `ctl_cont`=1 and `out_en`=1, `tone_out` follows the internal tone and `tone_active` is 1, whatever the level of `mod_in`.
- R3: With `ctl_cont`=0, `ctl_ext`=0 and `out_en`=1, `tone_out` is the internal tone while a burst is active and 0 otherwise.
- R4: With `ctl_cont`=0, `ctl_ext`=1 and `out_en`=1, `tone_out` equals `mod_in` delayed by two clock cycles.
- R5: A burst is active while the synchronised `mod_in` is high, or while fewer than HOLD_TICKS ticks (default 25) have passed since its last rising edge.
- R6: In switched mode, a rising edge that arrives after the hold has run out restarts the tone phase at 0. The first tone cycle of the burst is therefore whole and starts high.
- R7: `thr_tx` is `txt_in` OR `tth_bit`. A 1 selects the transmit threshold and a 0 selects the receive threshold.
- R8: With `ctl_cont`=1 and `ctl_ext`=1 together, the block behaves as in R2.
- R9: While `out_en` is 0, `tone_out` and `tone_active` are 0, and the phase and hold are cleared. In the cycle `out_en` returns to 1 the tone phase is 0, so the output is high.
- R10: `tone_active` is `out_en` AND (`ctl_cont` OR burst active).
- R11: Synchronous active-low reset clears the synchroniser, the phase and the hold. With `mod_in` high in switched mode during reset, `tone_active` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick | input | 1 | One-cycle pulse at twenty times the tone rate |
| out_en | input | 1 | Output enable; 0 forces the tone off |
| ctl_cont | input | 1 | Continuous tone control bit |
| ctl_ext | input | 1 | External modulated source select bit |
| mod_in | input | 1 | Asynchronous modulation / external tone pin |
| txt_in | input | 1 | Transmit indication pin for the detector threshold |
| tth_bit | input | 1 | Register bit forcing the transmit threshold |
| tone_active | output | 1 | Tone currently applied |
| tone_out | output | 1 | Tone square wave |
| thr_tx | output | 1 | Detector threshold select (1 transmit, 0 receive) |

## Verification
The bench looks for the end of a burst, ticking out the hold one tick at a time. A hold that is too short would cut a burst in the gaps of a square-wave envelope. One that is too long would leave the tone on after the gap has closed the burst. It checks that a fresh burst starts high at phase zero, where a design without the restart would begin with a part cycle. It also checks that the tone begins again at phase zero after the enable is dropped, and that it runs on unchanged when a new edge comes inside the hold. Random mode changes, including both control bits set at once, are compared against a model built from the requirements. This catches a wrong priority or a pass-through that is off by a cycle.

// File: rtl/tbg_pkg.sv
// Shared types for the tone burst generator.
package tbg_pkg;
    typedef enum logic [1:0] {
        SRC_GATED = 2'd0,
        SRC_EXT   = 2'd1,
        SRC_CONT  = 2'd2
    } src_mode_e;

    // Continuous control wins over the external select.
    function automatic src_mode_e pick_mode(input logic cont, input logic ext);
        if (cont)     return SRC_CONT;
        else if (ext) return SRC_EXT;
        else          return SRC_GATED;
    endfunction
endpackage

// File: rtl/tbg_sync.sv
// Multi-flop synchroniser for an asynchronous pin.
// Also gives an early rise flag. This flag is high in the cycle before the last stage goes high.
// Assumes STAGES >= 2.
module tbg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q,
    output logic rise_next
);
    logic [STAGES-1:0] chain;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            // Shift one stage of the chain.
            always_ff @(posedge clk) begin
                if (!rst_n)       chain[gi] <= 1'b0;
                else if (gi == 0) chain[gi] <= d_in;
                else              chain[gi] <= chain[(gi == 0) ? 0 : gi-1];
            end
        end
    endgenerate

    assign q         = chain[STAGES-1];
    assign rise_next = chain[STAGES-2] & ~chain[STAGES-1];
endmodule

// File: rtl/tbg_divider.sv
// Divides the oscillator tick to the tone rate. The output is high for the first half of the phase count.
// Assumes DIV_RATIO is even and >= 2; clr and !run both force phase 0.
module tbg_divider #(
    parameter int DIV_RATIO = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    input  logic tick,
    output logic phase_high
);
    localparam int CNT_W = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
    localparam int HALF  = DIV_RATIO / 2;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_RATIO - 1);

    logic [CNT_W-1:0] phase;

    // Advance the tone phase on each tick, wrapping at the ratio.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || clr) phase <= '0;
        else if (tick)             phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end

    assign phase_high = (phase < CNT_W'(HALF));

    p_phase_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= LAST);
    p_phase_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr && !tick) |=> $stable(phase));
endmodule

// File: rtl/tbg_hold.sv
// Burst hold timer. It reloads on each rising edge of the modulation pin and counts down one step per tick.
// Assumes the caller supplies the rise flag one cycle early, so the reload lines up with the synchronised level.
module tbg_hold #(
    parameter int HOLD_TICKS = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic rise,
    input  logic tick,
    output logic busy
);
    localparam int HOLD_W = $clog2(HOLD_TICKS + 1);
    localparam logic [HOLD_W-1:0] LOAD = HOLD_W'(HOLD_TICKS);

    logic [HOLD_W-1:0] left;

    // Reload on an edge, otherwise count the window down.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)            left <= '0;
        else if (rise)                 left <= LOAD;
        else if (tick && left != '0)   left <= left - 1'b1;
    end

    assign busy = (left != '0);

    p_hold_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && rise) |=> (left == LOAD));
    p_hold_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !rise && tick && left != '0) |=> (left == $past(left) - 1'b1));
endmodule

// File: rtl/tone_burst_gen.sv
// Tone burst generator top. It selects among three sources:
// the continuous internal tone, the internal tone gated by the modulation pin, or the external tone passed through.
// Assumes osc_tick is a single-cycle pulse at DIV_RATIO times the tone rate.
// mod_in is asynchronous.
module tone_burst_gen
    import tbg_pkg::*;
#(
    parameter int DIV_RATIO   = 20,
    parameter int HOLD_MARGIN = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic out_en,
    input  logic ctl_cont,
    input  logic ctl_ext,
    input  logic mod_in,
    input  logic txt_in,
    input  logic tth_bit,
    output logic tone_active,
    output logic tone_out,
    output logic thr_tx
);
    localparam int HOLD_TICKS = DIV_RATIO + HOLD_MARGIN;

    src_mode_e mode;
    logic      mod_s;
    logic      mod_rise;
    logic      hold_busy;
    logic      burst;
    logic      tone_sq;
    logic      phase_clr;

    assign mode = pick_mode(ctl_cont, ctl_ext);

    tbg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(mod_in),
        .q(mod_s), .rise_next(mod_rise)
    );

    tbg_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk(clk), .rst_n(rst_n), .run(out_en),
        .rise(mod_rise), .tick(osc_tick), .busy(hold_busy)
    );

    // A fresh burst in gated mode restarts the tone phase.
    assign phase_clr = (mode == SRC_GATED) && mod_rise && !hold_busy;

    tbg_divider #(.DIV_RATIO(DIV_RATIO)) u_div (
        .clk(clk), .rst_n(rst_n), .run(out_en),
        .clr(phase_clr), .tick(osc_tick), .phase_high(tone_sq)
    );

    assign burst = mod_s | hold_busy;

    // Route the selected source to the output.
    always_comb begin
        tone_out    = 1'b0;
        tone_active = 1'b0;
        if (out_en) begin
            unique case (mode)
                SRC_CONT: begin
                    tone_out    = tone_sq;
                    tone_active = 1'b1;
                end
                SRC_EXT: begin
                    tone_out    = mod_s;
                    tone_active = burst;
                end
                default: begin
                    tone_out    = burst & tone_sq;
                    tone_active = burst;
                end
            endcase
        end
    end

    assign thr_tx = txt_in | tth_bit;

    p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (!tone_out && !tone_active));
    p_restart_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        phase_clr |=> tone_sq);
endmodule

// File: tb/sim_tone_burst_gen.sv
// Self-checking bench for tone_burst_gen: directed corner cases and a seeded random run against a model.
module sim_tone_burst_gen;
    localparam int DIV  = 20;
    localparam int HOLD = 25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_tick = 1'b0, out_en = 1'b0, ctl_cont = 1'b0, ctl_ext = 1'b0;
    logic mod_in = 1'b0, txt_in = 1'b0, tth_bit = 1'b0;
    logic tone_active, tone_out, thr_tx;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit model_on = 0;

    int m_s1, m_s2, m_cnt, m_hold;

    always #4 clk = ~clk;

    tone_burst_gen u0 (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .out_en(out_en),
        .ctl_cont(ctl_cont), .ctl_ext(ctl_ext), .mod_in(mod_in),
        .txt_in(txt_in), .tth_bit(tth_bit),
        .tone_active(tone_active), .tone_out(tone_out), .thr_tx(thr_tx)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Requirement model, stepped at each rising edge.
    always @(posedge clk) begin
        int rise, gated, n_cnt, n_hold;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_cnt = 0; m_hold = 0;
        end else begin
            rise  = (m_s1 == 1 && m_s2 == 0) ? 1 : 0;
            gated = (!ctl_cont && !ctl_ext) ? 1 : 0;
            n_cnt = m_cnt; n_hold = m_hold;
            if (!out_en) begin
                n_cnt = 0; n_hold = 0;
            end else begin
                if (gated == 1 && rise == 1 && m_hold == 0) n_cnt = 0;
                else if (osc_tick) n_cnt = (m_cnt == DIV-1) ? 0 : m_cnt + 1;
                if (rise == 1) n_hold = HOLD;
                else if (osc_tick && m_hold != 0) n_hold = m_hold - 1;
            end
            m_cnt = n_cnt; m_hold = n_hold;
            m_s2 = m_s1; m_s1 = int'(mod_in);
        end
    end

    function automatic int exp_out(int oe, int ent, int msel);
        int sq, burst;
        sq = (m_cnt < DIV/2) ? 1 : 0;
        burst = (m_s2 == 1 || m_hold != 0) ? 1 : 0;
        if (oe == 0) return 0;
        if (ent == 1) return sq;
        if (msel == 1) return m_s2;
        return burst & sq;
    endfunction

    function automatic int exp_act(int oe, int ent);
        int burst;
        burst = (m_s2 == 1 || m_hold != 0) ? 1 : 0;
        return oe & (ent | burst);
    endfunction

    // Compare the outputs with the model away from the rising edge.
    always @(negedge clk) begin
        if (model_on && !done) begin
            string tag;
            if (!out_en)                 tag = "R9";
            else if (ctl_cont && ctl_ext) tag = "R8";
            else if (ctl_cont)           tag = "R2";
            else if (ctl_ext)            tag = "R4";
            else                         tag = "R3";
            chk({tag, " tone_out"}, int'(tone_out), exp_out(out_en, ctl_cont, ctl_ext));
            chk("R10 tone_active", int'(tone_active), exp_act(out_en, ctl_cont));
            chk("R7 thr_tx", int'(thr_tx), int'(txt_in | tth_bit));
        end
    end

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_up();
    end

    initial begin
        int highs;
        void'($urandom(32'h5EED_0042));
        // R11: reset holds the burst logic quiet with the pin high in gated mode.
        out_en = 1; mod_in = 1; osc_tick = 1;
        repeat (4) @(negedge clk);
        chk("R11 tone_active in reset", int'(tone_active), 0);
        chk("R11 tone_out in reset", int'(tone_out), 0);
        #1 rst_n = 1; out_en = 0; mod_in = 0;
        @(negedge clk);
        model_on = 1;

        // R7: all four threshold combinations.
        for (int k = 0; k < 4; k++) begin
            #1 txt_in = k[0]; tth_bit = k[1];
            @(negedge clk);
            chk("R7 threshold", int'(thr_tx), (k != 0) ? 1 : 0);
        end
        #1 txt_in = 0; tth_bit = 0;

        // R1/R9: restart on enable, then ten high ticks out of twenty.
        ctl_cont = 1; osc_tick = 1;
        repeat (3) @(negedge clk);
        #1 out_en = 1;
        #1 chk("R9 phase zero on enable", int'(tone_out), 1);
        highs = 0;
        for (int k = 0; k < DIV; k++) begin
            @(negedge clk);
            if (tone_out) highs++;
        end
        chk("R1 high ticks per period", highs, DIV/2);
        // R2: the pin has no effect in continuous mode.
        #1 mod_in = 1;
        repeat (6) @(negedge clk);
        chk("R2 active regardless of pin", int'(tone_active), 1);
        #1 mod_in = 0;

        // R5/R6: a fresh burst in gated mode, then the hold window runs out.
        ctl_cont = 0;
        repeat (HOLD + 6) @(negedge clk);
        chk("R5 idle before burst", int'(tone_active), 0);
        #1 mod_in = 1;
        @(negedge clk);
        chk("R5 synchroniser delay", int'(tone_active), 0);
        @(negedge clk);
        chk("R6 burst starts high", int'(tone_out), 1);
        chk("R5 burst active", int'(tone_active), 1);
        #1 mod_in = 0;
        for (int k = 1; k <= HOLD - 1; k++) @(negedge clk);
        chk("R5 still held at last tick", int'(tone_active), 1);
        @(negedge clk);
        chk("R5 burst ended after hold", int'(tone_active), 0);
        chk("R3 tone off after burst", int'(tone_out), 0);

        // Seeded random run over modes, enable, ticks and pin activity.
        for (int n = 0; n < 6000; n++) begin
            #1;
            osc_tick = ($urandom % 3) != 0;
            if ($urandom % 10 == 0) mod_in = ~mod_in;
            if ($urandom % 200 == 0) ctl_cont = $urandom % 2;
            if ($urandom % 200 == 0) ctl_ext = $urandom % 2;
            if ($urandom % 400 == 0) out_en = ~out_en;
            if ($urandom % 50 == 0) begin
                txt_in = $urandom % 2; tth_bit = $urandom % 2;
            end
            if ($urandom % 700 == 0) begin
                mod_in = 0;
                repeat (40) @(negedge clk);
                #1;
            end
            @(negedge clk);
        end
        finish_up();
    end
endmodule